// File: doc/BRIEF.md
# Card Configuration Register File

This block is the attribute-memory port of a removable ATA storage card. The host issues byte-wide reads and writes with an address. Addresses below the configuration base return bytes from a read-only card information structure (CIS) image, which is supplied as a parameter. Addresses at and above the base reach a small set of configuration registers: option, status, pin replacement and socket/copy.

The block also produces the card interrupt request. It takes the drive interrupt, the interrupt-disable bit of the device control register and that register's reset bit, and gates them together with the reset bit of the option register. When the host sets the option reset bit, the block sends a one-cycle soft-reset pulse to the rest of the card and clears its own registers. The drive task file and the data path are outside this block. The host reset input must already be synchronised to `clk`.

Top module: `cardcfg_regs`

## Requirements
- R1: A read from an address below the configuration base (default 0x200) returns CIS image byte `addr`, where byte 0 is the least significant byte of the image parameter. A read at an address at or past the image length, but still below the base, returns 0x00.
- R2: Read data appears on `rd_data` after the clock edge that samples the read strobe, and holds until the next read. Reads at base offset 6 (socket/copy) and at unmapped offsets return 0x00. Writes to the CIS region and to offset 6 change no register.
- R3: A write to base offset 0 (option) stores the written byte ANDed with 0xCF, so bits 5:4 always read zero.
- R4: A write to base offset 2 (status) keeps the current bits under mask 0x82 and loads the written bits under mask 0x74. Bits 0 and 3 always read zero, and bit 7 is never set.
- R5: A status write that changes status bit 2 (power-down) sets card-ready, bit 5 of the pin register. Card-ready stays set until a reset. A read at base offset 4 returns card-ready ORed with 0x0C. Writes to offset 4 do not change that readback.
- R6: Status bit 1 takes the value of `drive_irq` at every clock edge. A status read returns bit 1 as 0 while `ctl_irq_dis` is high.
- R7: `card_irq` is 1 exactly when status bit 1 is 0, `ctl_irq_dis` is 0, `ctl_srst` is 0 and option bit 7 is 0. It follows these inputs combinationally, with no clock delay.
- R8: An option write with bit 7 set raises `soft_rst` for exactly the one cycle after the write edge. The following edge clears the option register, the status register and card-ready, and host writes presented in the pulse cycle are dropped.
- R9: While `rst_n` is low, the option register returns to mode 0, status and card-ready clear, and `soft_rst` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Attribute-space byte address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| drive_irq | input | 1 | Interrupt level from the drive |
| ctl_irq_dis | input | 1 | Interrupt-disable bit of the device control register |
| ctl_srst | input | 1 | Soft-reset bit of the device control register |
| card_irq | output | 1 | Gated card interrupt request |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the rest of the card |

## Verification
Register writes and the drive interrupt are visible in state one edge after they are sampled. A read result is also due one edge after its strobe. The bench therefore drives each access for one cycle starting at a falling edge, and samples at the next falling edge. `card_irq` is combinational, so it is checked a short delay after an input changes, with no clock edge in between. `soft_rst` is checked at the falling edge just after the option write, and the cleared registers are read back after the edge that follows it.

// File: rtl/cardcfg_pkg.sv
package cardcfg_pkg;
  localparam int unsigned OFS_OPT  = 0;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_PIN  = 4;
  localparam int unsigned OFS_SOCK = 6;

  localparam logic [7:0] OPT_WMASK  = 8'hCF;
  localparam logic [7:0] STAT_KEEP  = 8'h82;
  localparam logic [7:0] STAT_LOAD  = 8'h74;
  localparam logic [7:0] PIN_CONST  = 8'h0C;

  localparam int unsigned OPT_SRST_BIT = 7;
  localparam int unsigned STAT_INT_BIT = 1;
  localparam int unsigned STAT_PWD_BIT = 2;
  localparam int unsigned PIN_RDY_BIT  = 5;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_ROM,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN
  } sel_e;
endpackage

// File: rtl/cardcfg_decode.sv
module cardcfg_decode
  import cardcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned CFG_BASE = 'h200,
  parameter int unsigned CIS_LEN  = 16,
  localparam int unsigned CIS_AW  = $clog2(CIS_LEN)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [CIS_AW-1:0] rom_idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(CIS_LEN);

  logic [ADDR_W-1:0] ofs;

  always_comb begin
    ofs     = addr - BASE_A;
    rom_idx = addr[CIS_AW-1:0];
    sel     = SEL_ZERO;
    if (addr < BASE_A) begin
      if (addr < LEN_A) sel = SEL_ROM;
    end else begin
      if (ofs == ADDR_W'(OFS_OPT))       sel = SEL_OPT;
      else if (ofs == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (ofs == ADDR_W'(OFS_PIN))  sel = SEL_PIN;
    end
  end
endmodule

// File: rtl/cardcfg_cis.sv
module cardcfg_cis #(
  parameter int unsigned      CIS_LEN   = 16,
  parameter logic [CIS_LEN*8-1:0] CIS_IMAGE = '0,
  localparam int unsigned     CIS_AW    = $clog2(CIS_LEN)
) (
  input  logic [CIS_AW-1:0] idx,
  output logic [7:0]        byte_o
);
  logic [7:0] rom [CIS_LEN];

  for (genvar g = 0; g < CIS_LEN; g++) begin : g_rom
    assign rom[g] = CIS_IMAGE[g*8 +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    if (32'(idx) < CIS_LEN) byte_o = rom[idx];
  end
endmodule

// File: rtl/cardcfg_state.sv
module cardcfg_state
  import cardcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_opt,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       drive_irq,
  output logic [7:0] opt_q,
  output logic [7:0] stat_q,
  output logic       rdy_q,
  output logic       srst_q
);
  logic [7:0] opt_nx, stat_nx;
  logic       rdy_nx, srst_nx, opt_en, rdy_en;

  always_comb begin
    opt_nx  = opt_q;
    stat_nx = stat_q;
    rdy_nx  = rdy_q;
    srst_nx = 1'b0;
    if (srst_q) begin
      opt_nx  = '0;
      stat_nx = '0;
      rdy_nx  = 1'b0;
    end else begin
      if (wr_opt) begin
        opt_nx  = wdata & OPT_WMASK;
        srst_nx = wdata[OPT_SRST_BIT];
      end
      if (wr_stat) begin
        stat_nx = (stat_q & STAT_KEEP) | (wdata & STAT_LOAD);
        if (wdata[STAT_PWD_BIT] != stat_q[STAT_PWD_BIT]) rdy_nx = 1'b1;
      end
      stat_nx[STAT_INT_BIT] = drive_irq;
    end
  end

  assign opt_en = srst_q | wr_opt;
  assign rdy_en = srst_q | wr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q  <= '0;
      stat_q <= '0;
      rdy_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (opt_en) opt_q <= opt_nx;
      if (rdy_en) rdy_q <= rdy_nx;
      stat_q <= stat_nx;
      srst_q <= srst_nx;
    end
  end

  a_r3_opt_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_q & ~OPT_WMASK) == 8'h00);
  a_r3_opt_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opt && !srst_q) |=> opt_q == ($past(wdata) & OPT_WMASK));
  a_r4_stat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[0] && !stat_q[3] && !stat_q[7]);
  a_r5_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !srst_q) |=> rdy_q);
  a_r6_int_track: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_q |=> stat_q[STAT_INT_BIT] == $past(drive_irq));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (opt_q == 8'h00) && (stat_q == 8'h00) && !rdy_q);
endmodule

// File: rtl/cardcfg_irq.sv
module cardcfg_irq (
  input  logic stat_int,
  input  logic opt_srst,
  input  logic ctl_irq_dis,
  input  logic ctl_srst,
  output logic card_irq
);
  logic blocked;

  always_comb begin
    blocked  = stat_int | opt_srst | ctl_irq_dis | ctl_srst;
    card_irq = ~blocked;
  end
endmodule

// File: rtl/cardcfg_regs.sv
module cardcfg_regs
  import cardcfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned CFG_BASE = 'h200,
  parameter int unsigned CIS_LEN  = 16,
  parameter logic [CIS_LEN*8-1:0] CIS_IMAGE = 128'h2001DF0218FF01D902041CFF01D90301
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              drive_irq,
  input  logic              ctl_irq_dis,
  input  logic              ctl_srst,
  output logic              card_irq,
  output logic              soft_rst
);
  localparam int unsigned CIS_AW = $clog2(CIS_LEN);

  sel_e              sel;
  logic [CIS_AW-1:0] rom_idx;
  logic [7:0]        rom_byte, opt_q, stat_q, rd_nx, rd_q;
  logic              rdy_q, srst_q, rd_en, wr_opt, wr_stat;

  cardcfg_decode #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CIS_LEN(CIS_LEN)) u_dec (
    .addr(acc_addr), .sel(sel), .rom_idx(rom_idx));

  cardcfg_cis #(.CIS_LEN(CIS_LEN), .CIS_IMAGE(CIS_IMAGE)) u_cis (
    .idx(rom_idx), .byte_o(rom_byte));

  assign wr_opt  = acc_en & acc_wr & (sel == SEL_OPT);
  assign wr_stat = acc_en & acc_wr & (sel == SEL_STAT);
  assign rd_en   = acc_en & ~acc_wr;

  cardcfg_state u_st (
    .clk(clk), .rst_n(rst_n), .wr_opt(wr_opt), .wr_stat(wr_stat),
    .wdata(wr_data), .drive_irq(drive_irq), .opt_q(opt_q),
    .stat_q(stat_q), .rdy_q(rdy_q), .srst_q(srst_q));

  cardcfg_irq u_irq (
    .stat_int(stat_q[STAT_INT_BIT]), .opt_srst(opt_q[OPT_SRST_BIT]),
    .ctl_irq_dis(ctl_irq_dis), .ctl_srst(ctl_srst), .card_irq(card_irq));

  always_comb begin
    unique case (sel)
      SEL_ROM:  rd_nx = rom_byte;
      SEL_OPT:  rd_nx = opt_q;
      SEL_STAT: begin
        rd_nx = stat_q;
        if (ctl_irq_dis) rd_nx[STAT_INT_BIT] = 1'b0;
      end
      SEL_PIN:  rd_nx = PIN_CONST | (8'(rdy_q) << PIN_RDY_BIT);
      default:  rd_nx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'h00;
    else if (rd_en) rd_q <= rd_nx;
  end

  assign rd_data  = rd_q;
  assign soft_rst = srst_q;

  a_r7_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !card_irq);
  a_r2_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && sel == SEL_ZERO) |=> rd_data == 8'h00);
  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> $stable(rd_data));
endmodule

// File: tb/sim_cardcfg_regs.sv
module sim_cardcfg_regs;
  localparam logic [127:0] IMG = 128'h2001DF0218FF01D902041CFF01D90301;
  localparam int NV = 24;
  // {wr, addr[9:0], data}: for reads, data is the expected byte
  localparam logic [18:0] VECS [NV] = '{
    {1'b0, 10'h000, 8'h01}, {1'b0, 10'h00F, 8'h20}, {1'b0, 10'h00D, 8'hDF},
    {1'b0, 10'h010, 8'h00}, {1'b0, 10'h1FF, 8'h00}, {1'b1, 10'h200, 8'h3F},
    {1'b0, 10'h200, 8'h0F}, {1'b1, 10'h200, 8'h41}, {1'b0, 10'h200, 8'h41},
    {1'b1, 10'h202, 8'h70}, {1'b0, 10'h202, 8'h70}, {1'b0, 10'h204, 8'h0C},
    {1'b1, 10'h202, 8'hFF}, {1'b0, 10'h202, 8'h74}, {1'b0, 10'h204, 8'h2C},
    {1'b1, 10'h204, 8'h00}, {1'b0, 10'h204, 8'h2C}, {1'b1, 10'h206, 8'hFF},
    {1'b0, 10'h206, 8'h00}, {1'b1, 10'h1F0, 8'h55}, {1'b0, 10'h200, 8'h41},
    {1'b0, 10'h208, 8'h00}, {1'b1, 10'h202, 8'h00}, {1'b0, 10'h202, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, acc_en = 1'b0, acc_wr = 1'b0;
  logic [9:0] acc_addr = '0;
  logic [7:0] wr_data = '0, rd_data, rv;
  logic drive_irq = 1'b0, ctl_irq_dis = 1'b0, ctl_srst = 1'b0;
  logic card_irq, soft_rst;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cardcfg_regs #(.CIS_IMAGE(IMG)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data),
    .drive_irq(drive_irq), .ctl_irq_dis(ctl_irq_dis), .ctl_srst(ctl_srst),
    .card_irq(card_irq), .soft_rst(soft_rst));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; wr_data = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    v = rd_data;
  endtask

  function automatic string tag_of(input logic [9:0] a);
    if (a < 10'h200) return "R1";
    if (a == 10'h200) return "R3";
    if (a == 10'h202) return "R4";
    if (a == 10'h204) return "R5";
    return "R2";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rd_data", rd_data, 8'h00);
    chk("R9 soft_rst", {7'b0, soft_rst}, 8'h00);
    rst_n = 1'b1;
    do_read(10'h200, rv); chk("R9 option", rv, 8'h00);
    do_read(10'h202, rv); chk("R9 status", rv, 8'h00);
    do_read(10'h204, rv); chk("R9 pin", rv, 8'h0C);
    chk("R7 idle irq", {7'b0, card_irq}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][18]) do_write(VECS[i][17:8], VECS[i][7:0]);
      else begin
        do_read(VECS[i][17:8], rv);
        chk(tag_of(VECS[i][17:8]), rv, VECS[i][7:0]);
      end
    end

    // R6: drive interrupt lands in status bit 1, hidden while disabled
    @(negedge clk); drive_irq = 1'b1;
    @(negedge clk);
    chk("R6/R7 irq blocked by drive", {7'b0, card_irq}, 8'h00);
    do_read(10'h202, rv); chk("R6 status int", rv, 8'h02);
    ctl_irq_dis = 1'b1;
    do_read(10'h202, rv); chk("R6 status hidden", rv, 8'h00);
    ctl_irq_dis = 1'b0; drive_irq = 1'b0;
    @(negedge clk);
    chk("R7 irq restored", {7'b0, card_irq}, 8'h01);

    // R7: control inputs act without a clock edge
    #2 ctl_srst = 1'b1;
    #1 chk("R7 ctl_srst gate", {7'b0, card_irq}, 8'h00);
    ctl_srst = 1'b0; ctl_irq_dis = 1'b1;
    #1 chk("R7 ctl_irq_dis gate", {7'b0, card_irq}, 8'h00);
    ctl_irq_dis = 1'b0;
    #1 chk("R7 ungated", {7'b0, card_irq}, 8'h01);

    // R8: option soft reset
    do_write(10'h202, 8'h04);
    do_write(10'h200, 8'h80);
    chk("R8 pulse high", {7'b0, soft_rst}, 8'h01);
    chk("R7 irq off in pulse", {7'b0, card_irq}, 8'h00);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 10'h202; wr_data = 8'h70;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    chk("R8 pulse one cycle", {7'b0, soft_rst}, 8'h00);
    do_read(10'h200, rv); chk("R8 option cleared", rv, 8'h00);
    do_read(10'h202, rv); chk("R8 status cleared, write dropped", rv, 8'h00);
    do_read(10'h204, rv); chk("R8 ready cleared", rv, 8'h0C);

    // R9: hard reset mid-run
    do_write(10'h200, 8'h0F);
    do_write(10'h202, 8'h04);
    do_read(10'h200, rv); chk("R3 before reset", rv, 8'h0F);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R9 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    do_read(10'h200, rv); chk("R9 option after reset", rv, 8'h00);
    do_read(10'h204, rv); chk("R9 pin after reset", rv, 8'h0C);
    chk("R9 soft_rst low", {7'b0, soft_rst}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule